// File: doc/BRIEF.md
# Circular Trace Buffer Write Controller

This block stores trace packets into an SRAM window that behaves as a circular buffer whose size is a power of two. Each accepted packet is 8 bytes wide. While tracing is enabled, a packet is written to the byte address held in a write pointer, and the pointer then moves forward by 8 bytes. Only the low pointer bits selected by a size field take part in the count. When the count rolls over, those bits return to zero and a wrap flag is raised. The pointer bits above the count are left alone, so the buffer can sit at any address that is a multiple of its own size.

Software controls the block through three 32-bit registers on a simple register port that carries a privilege attribute. Tracing can be started and stopped from two external level inputs, and each of them has its own enable bit. A watermark address can raise a halt request and, when autostop is set, stop tracing. A separate gate applies a privilege rule to bus accesses into the buffer SRAM: reads return zero and writes are blocked for user accesses. The halt request output is active only while the debug-allow input is high.

Top module: `trace_ring_ctrl`

## Requirements
- R1: After reset, all three registers read zero, `mem_we` is low and `halt_req_o` is low.
- R2: While CTRL.en (bit 31) is 1 and `pkt_valid` is high, `mem_we` is high in the same cycle, `mem_addr` equals the pointer byte address and `mem_wdata` equals `pkt_data`. The pointer is 8 bytes higher from the next cycle. While en is 0, `mem_we` stays low and the pointer does not move.
- R3: CTRL.size (bits 4:0) sets the buffer to 2^(size+4) bytes. When an advance carries out of byte-address bit size+3, byte-address bits size+3:3 become zero, the higher bits are kept, and POS.wrap (bit 2) becomes 1.
- R4: A size value above AW-4 acts exactly like AW-4.
- R5: If CTRL.start_en (bit 5) is 1 and `start_in` is high, en is 1 from the next cycle.
- R6: If CTRL.stop_en (bit 6) is 1 and `stop_in` is high, en is 0 from the next cycle. A packet presented in that cycle is still written. Stop wins over a start in the same cycle.
- R7: If CTRL.wpriv (bit 7) is 1, register writes with `reg_priv` low are ignored and privileged writes take effect. If wpriv is 0, both kinds of write take effect.
- R8: If CTRL.ram_priv (bit 8) is 1, an SRAM bus access with `ram_acc_priv` low gives `ram_rd_data` = 0 and `ram_wr_ok` low. Otherwise `ram_rd_data` = `ram_rd_raw` and `ram_wr_ok` = `ram_acc_wr`.
- R9: `halt_req_o` is high exactly when CTRL.halt (bit 9) is 1 and `dbg_allow` is high.
- R10: FLOW (reg_addr 2) holds a watermark byte address in bits AW-1:3 and autostop in bit 0. Writing a packet at the watermark address sets CTRL.halt from the next cycle. If autostop is 1, it also clears en, so the next packet is not written.
- R11: The register addresses are CTRL=0, POS=1 and FLOW=2. POS holds the pointer in bits AW-1:3 and wrap in bit 2. Reads are combinational and writes are visible from the next cycle. A software POS write wins over a pointer advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Trace packet present |
| pkt_data | input | 64 | Trace packet payload |
| mem_we | output | 1 | SRAM write strobe for a trace packet |
| mem_addr | output | AW | SRAM byte address of the packet |
| mem_wdata | output | 64 | SRAM write data |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | Access is a write |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_priv | input | 1 | Access is privileged |
| reg_rdata | output | 32 | Register read data |
| ram_acc_wr | input | 1 | SRAM bus access is a write |
| ram_acc_priv | input | 1 | SRAM bus access is privileged |
| ram_rd_raw | input | 64 | Read data from SRAM |
| ram_rd_data | output | 64 | Gated read data to the bus |
| ram_wr_ok | output | 1 | SRAM bus write allowed |
| start_in | input | 1 | Trace start level |
| stop_in | input | 1 | Trace stop level |
| dbg_allow | input | 1 | Debug permitted |
| halt_req_o | output | 1 | Halt request |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `start_in` and `stop_in` are levels, counted once in each cycle they are high. The stimulus therefore changes all inputs on the falling edge, and it holds start and stop high for a single cycle when the test needs exactly one event. The register port is only driven with the three defined addresses. Each register access lasts exactly one cycle, so a write is never counted twice.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_POS  = 2'd1,
    RA_FLOW = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic       en;
    logic       halt;
    logic       ram_priv;
    logic       wpriv;
    logic       stop_en;
    logic       start_en;
    logic [4:0] size;
  } ctrl_t;

  localparam int PKT_W = 64;
  localparam int REG_W = 32;
endpackage

// File: rtl/trc_ptr.sv
module trc_ptr
  import trc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    size,
  input  logic          adv,
  input  logic          sw_wr,
  input  logic [AW-4:0] sw_ptr,
  input  logic          sw_wrap,
  output logic [AW-4:0] ptr_q,
  output logic          wrap_q
);
  localparam int PW = AW - 3;
  localparam logic [4:0] SZ_MAX = 5'(AW - 4);

  logic [4:0]    sz_eff;
  logic [PW-1:0] lm;
  logic [PW-1:0] ptr_d;
  logic          wrap_d;
  logic          ptr_ce;

  assign sz_eff = (size > SZ_MAX) ? SZ_MAX : size;

  for (genvar i = 0; i < PW; i++) begin : g_lm
    assign lm[i] = (5'(i) <= sz_eff);
  end

  assign ptr_ce = sw_wr | adv;

  always_comb begin
    ptr_d  = ptr_q;
    wrap_d = wrap_q;
    if (sw_wr) begin
      ptr_d  = sw_ptr;
      wrap_d = sw_wrap;
    end else if (adv) begin
      ptr_d = (ptr_q & ~lm) | ((ptr_q + PW'(1)) & lm);
      if ((ptr_q & lm) == lm) wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (ptr_ce) begin
      ptr_q  <= ptr_d;
      wrap_q <= wrap_d;
    end
  end

  // R3
  wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sw_wr && ((ptr_q & lm) == lm)) |=> (wrap_q && ((ptr_q & $past(lm)) == '0)));

  // R3
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sw_wr) |=> ((ptr_q & ~$past(lm)) == $past(ptr_q & ~lm)));
endmodule

// File: rtl/trc_regs.sv
module trc_regs
  import trc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_priv,
  input  logic              start_in,
  input  logic              stop_in,
  input  logic              wm_hit,
  output ctrl_t             ctrl_q,
  output logic [AW-4:0]     wm_q,
  output logic              autostop_q,
  output logic              pos_wr
);
  ctrl_t         ctrl_d;
  logic          wr_ok, wr_ctrl, wr_flow;
  logic          start_hit, stop_hit, wm_stop;
  logic          ctrl_ce;
  logic          unused_wd;

  assign unused_wd = ^reg_wdata;

  assign wr_ok   = reg_sel && reg_wr && (!ctrl_q.wpriv || reg_priv);
  assign wr_ctrl = wr_ok && (reg_addr == RA_CTRL);
  assign pos_wr  = wr_ok && (reg_addr == RA_POS);
  assign wr_flow = wr_ok && (reg_addr == RA_FLOW);

  assign start_hit = ctrl_q.start_en && start_in;
  assign stop_hit  = ctrl_q.stop_en && stop_in;
  assign wm_stop   = wm_hit && autostop_q;
  assign ctrl_ce   = wr_ctrl | start_hit | stop_hit | wm_hit;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en       = reg_wdata[31];
      ctrl_d.halt     = reg_wdata[9];
      ctrl_d.ram_priv = reg_wdata[8];
      ctrl_d.wpriv    = reg_wdata[7];
      ctrl_d.stop_en  = reg_wdata[6];
      ctrl_d.start_en = reg_wdata[5];
      ctrl_d.size     = reg_wdata[4:0];
    end
    if (wm_hit) ctrl_d.halt = 1'b1;
    if (stop_hit || wm_stop) ctrl_d.en = 1'b0;
    else if (start_hit)      ctrl_d.en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q       <= '0;
      autostop_q <= 1'b0;
    end else if (wr_flow) begin
      wm_q       <= reg_wdata[AW-1:3];
      autostop_q <= reg_wdata[0];
    end
  end

  // R6
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !ctrl_q.en);

  // R5
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && !stop_hit && !wm_stop) |=> ctrl_q.en);

  // R7
  user_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && !reg_priv && ctrl_q.wpriv) |=> ($stable(ctrl_q.size) && $stable(wm_q)));

  // R10
  wm_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wm_hit |=> ctrl_q.halt);
endmodule

// File: rtl/trc_ram_gate.sv
module trc_ram_gate
  import trc_pkg::*;
(
  input  logic             ram_priv_en,
  input  logic             ram_acc_wr,
  input  logic             ram_acc_priv,
  input  logic [PKT_W-1:0] ram_rd_raw,
  output logic [PKT_W-1:0] ram_rd_data,
  output logic             ram_wr_ok
);
  logic blocked;

  assign blocked     = ram_priv_en && !ram_acc_priv;
  assign ram_rd_data = blocked ? '0 : ram_rd_raw;
  assign ram_wr_ok   = ram_acc_wr && !blocked;

  // R8
  always_comb begin
    ram_gate_chk: assert (!(ram_wr_ok && ram_priv_en && !ram_acc_priv));
  end
endmodule

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl
  import trc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [63:0]      pkt_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [63:0]      mem_wdata,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_priv,
  output logic [31:0]      reg_rdata,
  input  logic             ram_acc_wr,
  input  logic             ram_acc_priv,
  input  logic [63:0]      ram_rd_raw,
  output logic [63:0]      ram_rd_data,
  output logic             ram_wr_ok,
  input  logic             start_in,
  input  logic             stop_in,
  input  logic             dbg_allow,
  output logic             halt_req_o
);
  localparam int PW = AW - 3;

  logic          rst_s1, rst_s2;
  ctrl_t         ctrl_q;
  logic [PW-1:0] wm_q, ptr_q;
  logic          autostop_q, pos_wr, wrap_q, wm_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign mem_we    = ctrl_q.en && pkt_valid;
  assign mem_addr  = {ptr_q, 3'b000};
  assign mem_wdata = pkt_data;
  assign wm_hit    = mem_we && (ptr_q == wm_q);
  assign halt_req_o = ctrl_q.halt && dbg_allow;

  trc_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_s2),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_priv(reg_priv),
    .start_in(start_in), .stop_in(stop_in), .wm_hit(wm_hit),
    .ctrl_q(ctrl_q), .wm_q(wm_q), .autostop_q(autostop_q), .pos_wr(pos_wr)
  );

  trc_ptr #(.AW(AW)) ptr_i (
    .clk(clk), .rst_n(rst_s2), .size(ctrl_q.size), .adv(mem_we),
    .sw_wr(pos_wr), .sw_ptr(reg_wdata[AW-1:3]), .sw_wrap(reg_wdata[2]),
    .ptr_q(ptr_q), .wrap_q(wrap_q)
  );

  trc_ram_gate gate_i (
    .ram_priv_en(ctrl_q.ram_priv), .ram_acc_wr(ram_acc_wr),
    .ram_acc_priv(ram_acc_priv), .ram_rd_raw(ram_rd_raw),
    .ram_rd_data(ram_rd_data), .ram_wr_ok(ram_wr_ok)
  );

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {ctrl_q.en, 21'b0, ctrl_q.halt, ctrl_q.ram_priv,
                            ctrl_q.wpriv, ctrl_q.stop_en, ctrl_q.start_en, ctrl_q.size};
      RA_POS:  reg_rdata = {{(32-AW){1'b0}}, ptr_q, wrap_q, 2'b00};
      RA_FLOW: reg_rdata = {{(32-AW){1'b0}}, wm_q, 2'b00, autostop_q};
      default: reg_rdata = '0;
    endcase
  end

  // R2
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (!ctrl_q.en && !pos_wr) |=> $stable(ptr_q));
endmodule

// File: tb/trace_ring_ctrl_tb.sv
`timescale 1ns/1ps
module trace_ring_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt_data = '0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_priv = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ram_acc_wr = 1'b0, ram_acc_priv = 1'b0;
  logic [63:0] ram_rd_raw = '0, ram_rd_data;
  logic        ram_wr_ok;
  logic        start_in = 1'b0, stop_in = 1'b0, dbg_allow = 1'b0;
  logic        halt_req_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [31:0] d;
  logic        s_we;
  logic [15:0] s_addr;
  logic [63:0] s_wd;

  always #4 clk = ~clk;

  trace_ring_ctrl #(.AW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_priv(reg_priv), .reg_rdata(reg_rdata),
    .ram_acc_wr(ram_acc_wr), .ram_acc_priv(ram_acc_priv), .ram_rd_raw(ram_rd_raw),
    .ram_rd_data(ram_rd_data), .ram_wr_ok(ram_wr_ok),
    .start_in(start_in), .stop_in(stop_in), .dbg_allow(dbg_allow),
    .halt_req_o(halt_req_o)
  );

  // {size, start byte address, expected byte address, expected wrap}
  localparam logic [37:0] VEC [8] = '{
    {5'd0,  16'h0100, 16'h0108, 1'b0},
    {5'd0,  16'h0108, 16'h0100, 1'b1},
    {5'd2,  16'h1230, 16'h1238, 1'b0},
    {5'd2,  16'h1238, 16'h1200, 1'b1},
    {5'd12, 16'hFFF8, 16'h0000, 1'b1},
    {5'd31, 16'hFFF8, 16'h0000, 1'b1},
    {5'd5,  16'h41F8, 16'h4000, 1'b1},
    {5'd5,  16'h40F8, 16'h4100, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic pkt(input logic [63:0] v);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = v;
    #1 s_we = mem_we; s_addr = mem_addr; s_wd = mem_wdata;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mem_we", {63'b0, mem_we}, 64'd0);
    chk("R1 halt", {63'b0, halt_req_o}, 64'd0);
    rd(2'd0, d); chk("R1 ctrl", {32'b0, d}, 64'd0);
    rd(2'd1, d); chk("R1 pos", {32'b0, d}, 64'd0);
    rd(2'd2, d); chk("R1 flow", {32'b0, d}, 64'd0);

    // R3 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {1'b1, 26'b0, VEC[i][37:33]});
      wr(2'd1, {16'b0, VEC[i][32:17]});
      pkt(64'(i));
      rd(2'd1, d);
      chk($sformatf("R3 R4 vec%0d", i), {32'b0, d},
          {48'b0, VEC[i][16:1] | {13'b0, VEC[i][0], 2'b00}});
    end

    // R2 disabled then enabled
    wr(2'd0, 32'h0000_000C);
    wr(2'd1, 32'h0000_0040);
    pkt(64'h55);
    chk("R2 idle no write", {63'b0, s_we}, 64'd0);
    rd(2'd1, d); chk("R2 idle ptr", {32'b0, d}, 64'h40);
    wr(2'd0, 32'h8000_000C);
    pkt(64'h1122_3344_5566_7788);
    chk("R2 we", {63'b0, s_we}, 64'd1);
    chk("R2 addr", {48'b0, s_addr}, 64'h40);
    chk("R2 data", s_wd, 64'h1122_3344_5566_7788);
    rd(2'd1, d); chk("R2 advance", {32'b0, d}, 64'h48);

    // R5 start
    wr(2'd0, 32'h0000_002C);
    @(negedge clk); start_in = 1'b1;
    @(negedge clk); start_in = 1'b0;
    rd(2'd0, d); chk("R5 start", {32'b0, d}, 64'h8000_002C);

    // R6 stop finishes packet in flight
    wr(2'd0, 32'h8000_004C);
    @(negedge clk); stop_in = 1'b1; pkt_valid = 1'b1;
    #1 chk("R6 write in stop cycle", {63'b0, mem_we}, 64'd1);
    @(negedge clk); stop_in = 1'b0; pkt_valid = 1'b0;
    rd(2'd0, d); chk("R6 stopped", {32'b0, d}, 64'h0000_004C);
    // R6 stop beats start
    wr(2'd0, 32'h8000_006C);
    @(negedge clk); stop_in = 1'b1; start_in = 1'b1;
    @(negedge clk); stop_in = 1'b0; start_in = 1'b0;
    rd(2'd0, d); chk("R6 stop priority", {32'b0, d}, 64'h0000_006C);

    // R7 write privilege
    wr(2'd0, 32'h0000_0080);
    reg_priv = 1'b0;
    wr(2'd0, 32'h0000_0003);
    wr(2'd2, 32'h0000_0011);
    reg_priv = 1'b1;
    rd(2'd0, d); chk("R7 user ctrl ignored", {32'b0, d}, 64'h80);
    rd(2'd2, d); chk("R7 user flow ignored", {32'b0, d}, 64'h0);
    wr(2'd0, 32'h0000_0003);
    rd(2'd0, d); chk("R7 priv write", {32'b0, d}, 64'h3);
    reg_priv = 1'b0;
    wr(2'd0, 32'h0000_0005);
    reg_priv = 1'b1;
    rd(2'd0, d); chk("R7 user write open", {32'b0, d}, 64'h5);

    // R8 SRAM privilege gate
    wr(2'd0, 32'h0000_0100);
    @(negedge clk);
    ram_rd_raw = 64'hDEAD_BEEF_0123_4567; ram_acc_wr = 1'b1; ram_acc_priv = 1'b0;
    #1 chk("R8 user read zero", ram_rd_data, 64'd0);
    chk("R8 user write blocked", {63'b0, ram_wr_ok}, 64'd0);
    ram_acc_priv = 1'b1;
    #1 chk("R8 priv read", ram_rd_data, 64'hDEAD_BEEF_0123_4567);
    chk("R8 priv write", {63'b0, ram_wr_ok}, 64'd1);
    wr(2'd0, 32'h0000_0000);
    ram_acc_priv = 1'b0;
    #1 chk("R8 open user read", ram_rd_data, 64'hDEAD_BEEF_0123_4567);
    chk("R8 open user write", {63'b0, ram_wr_ok}, 64'd1);
    ram_acc_wr = 1'b0;

    // R9 halt output
    wr(2'd0, 32'h0000_0200);
    dbg_allow = 1'b0;
    #1 chk("R9 halt no dbg", {63'b0, halt_req_o}, 64'd0);
    dbg_allow = 1'b1;
    #1 chk("R9 halt dbg", {63'b0, halt_req_o}, 64'd1);
    wr(2'd0, 32'h0000_0000);
    #1 chk("R9 halt bit off", {63'b0, halt_req_o}, 64'd0);
    dbg_allow = 1'b0;

    // R10 watermark with autostop
    wr(2'd2, 32'h0000_0211);
    wr(2'd1, 32'h0000_0208);
    wr(2'd0, 32'h8000_000C);
    pkt(64'hA1);
    rd(2'd0, d); chk("R10 before mark", {32'b0, d}, 64'h8000_000C);
    pkt(64'hA2);
    chk("R10 mark written", {63'b0, s_we}, 64'd1);
    rd(2'd0, d); chk("R10 halt and stop", {32'b0, d}, 64'h0000_020C);
    pkt(64'hA3);
    chk("R10 no write after", {63'b0, s_we}, 64'd0);
    rd(2'd2, d); chk("R11 flow readback", {32'b0, d}, 64'h0211);

    // R11 software position write beats advance
    wr(2'd2, 32'h0000_0000);
    wr(2'd0, 32'h8000_000C);
    wr(2'd1, 32'h0000_0100);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0800;
    pkt_valid = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; pkt_valid = 1'b0;
    rd(2'd1, d); chk("R11 sw pos wins", {32'b0, d}, 64'h0800);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog req=all act=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule